// File: doc/BRIEF.md
# Receive descriptor status writeback engine

This block sits between a receive MAC and a ring of receive descriptors in host memory. It takes a frame as a byte stream and places the bytes into the buffers of the descriptors that the device currently owns, following each descriptor's next pointer. When a buffer fills or the frame ends, it writes a 32-bit status word back into the descriptor and clears that descriptor's ownership flag. This returns the descriptor to the host. One frame may therefore span several chained descriptors.

Per-frame sideband flags arrive with the last byte and are folded into the status of the final descriptor. These flags are CRC error, late collision, FIFO overflow, address miss, multicast, and two checksum results. The final status also carries the frame length, length-derived runt and oversize flags, and an error summary. A configuration input selects the meaning of bits 13:12: either checksum results or the loopback source. Descriptor reads, byte writes and status writes all share one request/acknowledge memory port.

Top module: `rx_desc_wb`

## Requirements
- R1: After reset, and while no frame byte is offered, `mem_req` and `in_ready` stay low. The first descriptor used lies at `BASE_ADDR`.
- R2: A descriptor is four words. Offset +0 holds the status word, where bit 31 set means the device owns it. Offset +4 holds the non-zero buffer length in bits LEN_W-1:0. Offset +8 holds the buffer byte address and offset +12 the next descriptor's address. Word +0 is read first, then +4, +8 and +12, before any byte is stored.
- R3: Byte k of a descriptor's share goes to buffer address + k as a single-byte write. The byte is repeated on all four lanes and `mem_be` is one-hot at `addr[1:0]`. No descriptor receives more bytes than its buffer length.
- R4: When a buffer fills and bytes remain, word +0 of the next descriptor is read. If that descriptor is owned, the current descriptor gets a status write with bit 8 clear, and storing continues in the next descriptor's buffer.
- R5: Every status write has bit 31 clear. Bit 9 is set only in the frame's first descriptor, and bit 8 only in its last.
- R6: A status write with bit 8 clear has bits 30:14, 11:10 and 7:0 at zero. In the end descriptor, bits 29:16 give the number of bytes stored. Bit 30 is the address miss flag, bit 10 multicast, bit 6 late collision, bit 1 CRC error and bit 0 FIFO overflow. These flags are sampled with the last byte.
- R7: The end descriptor has bit 11 (runt) set exactly when fewer than 64 bytes were stored and no FIFO overflow is reported.
- R8: The end descriptor has bit 7 set exactly when more than 1518 bytes were stored.
- R9: In the end descriptor, bit 15 is the OR of bits 14, 11, 7, 6, 1 and 0.
- R10: If a buffer fills with bytes remaining and the next descriptor is not owned, the current descriptor is closed. Its status has bits 8, 14 and 15 set, the stored count, and zero sideband bits. The rest of the frame is accepted and discarded, and the next frame starts at the non-owned descriptor.
- R11: A frame that begins while the current descriptor is not owned is accepted and discarded with no memory write. That descriptor is polled again when the next frame begins.
- R12: With `cfg_csum_en` high, bits 13:12 carry {IP checksum failure, TCP/UDP checksum failure} in the end descriptor and 00 elsewhere. With it low, they carry `cfg_loop_src` in every status write: 00 normal, 01 internal loopback, 10 PHY digital loopback, 11 PHY analog loopback.
- R13: A memory request holds its address, direction and write data until `mem_ack`. A one-cycle acknowledge ends the access, and read data is taken in the acknowledge cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_csum_en | input | 1 | Bits 13:12 report checksum results when high |
| cfg_loop_src | input | 2 | Loopback source code reported when checksum mode is off |
| in_valid | input | 1 | Frame byte offered |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Offered byte is the last of the frame |
| in_ready | output | 1 | Byte accepted on this edge when high with in_valid |
| fr_crc_err | input | 1 | Frame CRC error, sampled with last byte |
| fr_late_col | input | 1 | Late collision seen, sampled with last byte |
| fr_fifo_ovf | input | 1 | Receive FIFO overflow, sampled with last byte |
| fr_addr_miss | input | 1 | Destination address did not match, sampled with last byte |
| fr_mcast | input | 1 | Multicast destination, sampled with last byte |
| fr_ip_bad | input | 1 | IP checksum failed, sampled with last byte |
| fr_l4_bad | input | 1 | TCP/UDP checksum failed, sampled with last byte |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Byte address |
| mem_be | output | 4 | Byte lane enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | One-cycle access completion |
| mem_rdata | input | 32 | Read data, valid with mem_ack |

## Verification
The assertions watch the memory port on every cycle. They check that a pending request stays stable until acknowledged and that no byte write lands past the buffer length. They also check that non-end status words keep their error and length fields quiet, that a truncation always comes with the end marker and the summary bit, and that overflow suppresses the runt flag. Whether the right descriptor is closed at the right moment can only be shown by the bench's scenarios. The same holds for the chain being followed in order, the length-derived flags being correct, and discarded frames leaving memory untouched. The bench covers frames of 40, 64, 1518 and 1600 bytes, exact buffer fits, truncation and a frame arriving at a host-owned descriptor.

// File: rtl/rx_desc_wb.sv
module rx_desc_wb #(
  parameter int AW = 32,
  parameter int LEN_W = 11,
  parameter int RUNT_MIN = 64,
  parameter int MAX_LEN = 1518,
  parameter logic [AW-1:0] BASE_ADDR = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_csum_en,
  input  logic [1:0]    cfg_loop_src,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  input  logic          in_last,
  output logic          in_ready,
  input  logic          fr_crc_err,
  input  logic          fr_late_col,
  input  logic          fr_fifo_ovf,
  input  logic          fr_addr_miss,
  input  logic          fr_mcast,
  input  logic          fr_ip_bad,
  input  logic          fr_l4_bad,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [3:0]    mem_be,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata
);
  localparam int FL_W = 14;

  typedef enum logic [3:0] {
    S_IDLE, S_OWN, S_LEN, S_BUF, S_NXT, S_RDY, S_WR, S_CHK, S_ST, S_DROP
  } state_t;

  state_t st;
  logic [AW-1:0]    cur, nxt, bufa;
  logic [LEN_W-1:0] blen, off;
  logic [FL_W-1:0]  cnt;
  logic [7:0]       bq;
  logic lastq, first, ed, due;
  logic f_aun, f_mc, f_lc, f_crc, f_ovf, f_ip, f_l4;
  logic [31:0] status;

  wire acc = in_valid && in_ready;
  wire [LEN_W-1:0] off_n = off + LEN_W'(1);

  assign in_ready = (st == S_RDY) || (st == S_DROP);
  assign mem_req  = st inside {S_OWN, S_LEN, S_BUF, S_NXT, S_WR, S_CHK, S_ST};
  assign mem_we   = (st == S_WR) || (st == S_ST);

  always_comb begin
    case (st)
      S_LEN:   mem_addr = cur + AW'(4);
      S_BUF:   mem_addr = cur + AW'(8);
      S_NXT:   mem_addr = cur + AW'(12);
      S_CHK:   mem_addr = nxt;
      S_WR:    mem_addr = bufa + AW'(off);
      default: mem_addr = cur;
    endcase
  end

  wire runt = (cnt < FL_W'(RUNT_MIN)) && !f_ovf;
  wire efl  = cnt > FL_W'(MAX_LEN);
  wire es   = due | runt | efl | f_lc | f_crc | f_ovf;
  wire [1:0] mode = cfg_csum_en ? (ed ? {f_ip, f_l4} : 2'b00) : cfg_loop_src;

  assign status = ed ? {1'b0, f_aun, cnt, es, due, mode, runt, f_mc, first, 1'b1,
                        efl, f_lc, 4'b0000, f_crc, f_ovf}
                     : {18'd0, mode, 2'b00, first, 9'd0};

  assign mem_be    = (st == S_WR) ? (4'b0001 << mem_addr[1:0]) : 4'b1111;
  assign mem_wdata = (st == S_WR) ? {4{bq}} : status;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cur <= BASE_ADDR;
      nxt <= '0;
      bufa <= '0;
      blen <= '0;
      off <= '0;
      cnt <= '0;
      bq <= '0;
      lastq <= 1'b0;
      first <= 1'b0;
      ed <= 1'b0;
      due <= 1'b0;
      {f_aun, f_mc, f_lc, f_crc, f_ovf, f_ip, f_l4} <= '0;
    end else begin
      case (st)
        S_IDLE: if (in_valid) begin
          st <= S_OWN;
          cnt <= '0;
          first <= 1'b1;
          ed <= 1'b0;
          due <= 1'b0;
          {f_aun, f_mc, f_lc, f_crc, f_ovf, f_ip, f_l4} <= '0;
        end
        S_OWN: if (mem_ack) st <= mem_rdata[31] ? S_LEN : S_DROP;
        S_LEN: if (mem_ack) begin
          blen <= mem_rdata[LEN_W-1:0];
          st <= S_BUF;
        end
        S_BUF: if (mem_ack) begin
          bufa <= mem_rdata[AW-1:0];
          st <= S_NXT;
        end
        S_NXT: if (mem_ack) begin
          nxt <= mem_rdata[AW-1:0];
          off <= '0;
          st <= S_RDY;
        end
        S_RDY: if (acc) begin
          bq <= in_data;
          lastq <= in_last;
          if (in_last)
            {f_aun, f_mc, f_lc, f_crc, f_ovf, f_ip, f_l4} <=
              {fr_addr_miss, fr_mcast, fr_late_col, fr_crc_err, fr_fifo_ovf, fr_ip_bad, fr_l4_bad};
          st <= S_WR;
        end
        S_WR: if (mem_ack) begin
          off <= off_n;
          cnt <= cnt + FL_W'(1);
          if (lastq) begin
            ed <= 1'b1;
            st <= S_ST;
          end else if (off_n == blen) st <= S_CHK;
          else st <= S_RDY;
        end
        S_CHK: if (mem_ack) begin
          ed <= !mem_rdata[31];
          due <= !mem_rdata[31];
          st <= S_ST;
        end
        S_ST: if (mem_ack) begin
          cur <= nxt;
          if (ed) st <= due ? S_DROP : S_IDLE;
          else begin
            first <= 1'b0;
            st <= S_LEN;
          end
        end
        S_DROP: if (acc && in_last) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  wire st_wr = mem_req && mem_we && (mem_be == 4'hF);

  assert_req_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  assert_no_overrun_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && (st == S_WR) |-> off < blen);

  assert_owner_cleared_R5: assert property (@(posedge clk) disable iff (!rst_n)
    st_wr |-> !mem_wdata[31]);

  assert_mid_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    st_wr && !mem_wdata[8] |-> mem_wdata[30:14] == '0 && mem_wdata[11:10] == '0 && mem_wdata[7:0] == '0);

  assert_trunc_closes_R10: assert property (@(posedge clk) disable iff (!rst_n)
    st_wr && mem_wdata[14] |-> mem_wdata[8] && mem_wdata[15]);

  assert_ovf_no_runt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    st_wr && mem_wdata[0] |-> !mem_wdata[11]);
endmodule

// File: tb/tb_rx_desc_wb.sv
`timescale 1ns/1ps
module tb_rx_desc_wb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic cfg_csum_en = 1'b0;
  logic [1:0] cfg_loop_src = 2'b00;
  logic in_valid = 1'b0, in_last = 1'b0, in_ready;
  logic [7:0] in_data = 8'h00;
  logic fr_crc_err = 0, fr_late_col = 0, fr_fifo_ovf = 0, fr_addr_miss = 0;
  logic fr_mcast = 0, fr_ip_bad = 0, fr_l4_bad = 0;
  logic mem_req, mem_we, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic [3:0] mem_be;

  int checks = 0, errors = 0;
  logic [31:0] mem_w [0:8191];
  logic [31:0] qa[$], qd[$];
  logic [3:0] qb[$];
  string qt[$];
  bit own_m[12];
  int len_m[12], nxt_m[12];
  int cur_m = 0;
  logic [31:0] req_addr;

  rx_desc_wb dut (
    .clk(clk), .rst_n(rst_n), .cfg_csum_en(cfg_csum_en), .cfg_loop_src(cfg_loop_src),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
    .fr_crc_err(fr_crc_err), .fr_late_col(fr_late_col), .fr_fifo_ovf(fr_fifo_ovf),
    .fr_addr_miss(fr_addr_miss), .fr_mcast(fr_mcast), .fr_ip_bad(fr_ip_bad), .fr_l4_bad(fr_l4_bad),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata));

  task automatic finish_all();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // memory model and scoreboard monitor
  always @(posedge clk) begin
    if (!rst_n) mem_ack <= 1'b0;
    else if (mem_ack) begin
      mem_ack <= 1'b0;
      checks++;
      if (!(mem_req && mem_addr == req_addr)) begin
        errors++;
        $display("FAIL R13 req %b addr %h at ack, expected req 1 addr %h", mem_req, mem_addr, req_addr);
      end
    end else if (mem_req) begin
      mem_ack <= 1'b1;
      req_addr = mem_addr;
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem_w[mem_addr[14:2]][8*b +: 8] = mem_wdata[8*b +: 8];
        checks++;
        if (qa.size() == 0) begin
          errors++;
          $display("FAIL R11 unexpected write addr %h data %h be %h, expected none", mem_addr, mem_wdata, mem_be);
        end else begin
          logic [31:0] ea, ed;
          logic [3:0] eb;
          string et;
          ea = qa.pop_front(); ed = qd.pop_front(); eb = qb.pop_front(); et = qt.pop_front();
          if (mem_addr !== ea || mem_wdata !== ed || mem_be !== eb) begin
            errors++;
            $display("FAIL %s addr %h data %h be %h, expected addr %h data %h be %h",
                     et, mem_addr, mem_wdata, mem_be, ea, ed, eb);
          end
        end
      end else mem_rdata <= mem_w[mem_addr[14:2]];
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired, actual hung expected done");
    finish_all();
  end

  function automatic logic [31:0] bufaddr(int i);
    return 32'h400 + i * 32'h800;
  endfunction

  function automatic logic [7:0] bdat(int n, int k);
    return 8'((n * 3 + k * 13) & 255);
  endfunction

  function automatic logic [31:0] exp_st(int cnt, bit ed, bit first, bit due, bit aun, bit mc,
                                          bit lc, bit crc, bit ovf, bit ipf, bit l4f);
    logic [31:0] s = '0;
    bit runt, efl;
    s[9] = first;
    if (cfg_csum_en) s[13:12] = ed ? {ipf, l4f} : 2'b00;
    else s[13:12] = cfg_loop_src;
    if (ed) begin
      runt = (cnt < 64) && !ovf;
      efl = cnt > 1518;
      s[8] = 1'b1; s[30] = aun; s[29:16] = cnt[13:0]; s[14] = due; s[11] = runt;
      s[10] = mc; s[7] = efl; s[6] = lc; s[1] = crc; s[0] = ovf;
      s[15] = due | runt | efl | lc | crc | ovf;
    end
    return s;
  endfunction

  task automatic push(logic [31:0] a, logic [31:0] d, logic [3:0] be, string t);
    qa.push_back(a); qd.push_back(d); qb.push_back(be); qt.push_back(t);
  endtask

  task automatic set_desc(int i, bit own, int len, int nx);
    mem_w[4*i]   = own ? 32'h8000_0000 : 32'h0;
    mem_w[4*i+1] = len;
    mem_w[4*i+2] = bufaddr(i);
    mem_w[4*i+3] = 16 * nx;
    own_m[i] = own; len_m[i] = len; nxt_m[i] = nx;
  endtask

  task automatic run_frame(int n, bit aun, bit mc, bit lc, bit crc, bit ovf, bit ipf, bit l4f);
    int c = cur_m, off = 0;
    bit first = 1, done = 0, dropped;
    logic [31:0] a;
    dropped = !own_m[c];
    if (!dropped)
      for (int k = 0; k < n && !done; k++) begin
        a = bufaddr(c) + off;
        push(a, {4{bdat(n, k)}}, 4'b0001 << a[1:0], "R3 byte placement (layout R2)");
        off++;
        if (k == n - 1) begin
          push(16 * c, exp_st(k + 1, 1, first, 0, aun, mc, lc, crc, ovf, ipf, l4f), 4'hF,
               "R5 R6 R7 R8 R9 R12 end status");
          own_m[c] = 0; cur_m = nxt_m[c]; done = 1;
        end else if (off == len_m[c]) begin
          if (own_m[nxt_m[c]]) begin
            push(16 * c, exp_st(0, 0, first, 0, 0, 0, 0, 0, 0, 0, 0), 4'hF, "R4 R5 R12 chained status");
            own_m[c] = 0; c = nxt_m[c]; off = 0; first = 0;
          end else begin
            push(16 * c, exp_st(k + 1, 1, first, 1, 0, 0, 0, 0, 0, 0, 0), 4'hF, "R10 truncated status");
            own_m[c] = 0; cur_m = nxt_m[c]; done = 1;
          end
        end
      end
    {fr_addr_miss, fr_mcast, fr_late_col, fr_crc_err, fr_fifo_ovf, fr_ip_bad, fr_l4_bad} =
      {aun, mc, lc, crc, ovf, ipf, l4f};
    for (int k = 0; k < n; k++) begin
      in_valid = 1'b1; in_data = bdat(n, k); in_last = (k == n - 1);
      while (!in_ready) @(negedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0; in_last = 1'b0;
    repeat (30) @(negedge clk);
    checks++;
    if (qa.size() != 0 || mem_req) begin
      errors++;
      $display("FAIL %s pending writes %0d req %b, expected 0 and 0",
               dropped ? "R11" : "R4", qa.size(), mem_req);
      qa.delete(); qd.delete(); qb.delete(); qt.delete();
    end
  endtask

  initial begin
    for (int i = 0; i < 8192; i++) mem_w[i] = '0;
    for (int i = 0; i < 12; i++) set_desc(i, 0, 0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      checks++;
      if (mem_req !== 1'b0 || in_ready !== 1'b0) begin
        errors++;
        $display("FAIL R1 idle req %b ready %b, expected 0 0", mem_req, in_ready);
      end
      @(negedge clk);
    end
    // 40-byte runt with CRC error, loopback source 01
    cfg_loop_src = 2'b01;
    set_desc(0, 1, 128, 3);
    run_frame(40, 0, 0, 0, 1, 0, 0, 0);
    // 64 bytes spanning two descriptors, multicast and address miss
    set_desc(3, 1, 32, 1);
    set_desc(1, 1, 48, 4);
    run_frame(64, 1, 1, 0, 0, 0, 0, 0);
    // 1518 bytes across three buffers, checksum mode
    cfg_csum_en = 1'b1;
    set_desc(4, 1, 500, 2);
    set_desc(2, 1, 700, 5);
    set_desc(5, 1, 600, 0);
    run_frame(1518, 0, 0, 1, 0, 0, 1, 0);
    // 1600 bytes, oversize, loopback 11
    cfg_csum_en = 1'b0; cfg_loop_src = 2'b11;
    set_desc(0, 1, 1000, 3);
    set_desc(3, 1, 1000, 1);
    run_frame(1600, 0, 0, 0, 0, 0, 0, 0);
    // truncation: next descriptor host-owned
    cfg_loop_src = 2'b10;
    set_desc(1, 1, 64, 4);
    set_desc(4, 0, 0, 2);
    run_frame(100, 0, 1, 0, 1, 0, 0, 0);
    // frame arriving at a host-owned descriptor is dropped
    run_frame(50, 0, 0, 0, 0, 0, 0, 0);
    // exact fit after re-arming, FIFO overflow flagged
    cfg_loop_src = 2'b00;
    set_desc(4, 1, 64, 2);
    run_frame(64, 0, 0, 0, 0, 1, 0, 0);
    // short frame with overflow: no runt; checksum mode
    cfg_csum_en = 1'b1;
    set_desc(2, 1, 128, 5);
    run_frame(40, 0, 0, 0, 0, 1, 0, 1);
    // exact fit where the following descriptor is host-owned
    set_desc(5, 1, 64, 0);
    run_frame(64, 1, 0, 0, 0, 0, 1, 1);
    finish_all();
  end
endmodule